// File: doc/BRIEF.md
# Clocked Programmable Pulse Delay Line

This block reproduces a single-bit input waveform on its outputs after a delay chosen by a 7-bit code, with time counted in clock cycles. The delay is a fixed base latency plus one configurable step of cycles per code unit. Samples of the input move through a tapped shift register, and the tap is picked straight from the live code input. The code is not latched, so the integrator must hold it steady while edges are in flight.

Two outputs are driven: a true copy of the delayed signal and its complement. An active-low enable forces the true output low and the complement high while it is high. A settle flag reports that a guard window is still running. After a code increase, the window lasts the size of the increase times the step. After the output is disabled, the window lasts the code times the step so that the line can drain. During that window spurious edges may appear on the output if the line is put back into use.

Top module: `tap_delay_line`

## Requirements
- R1: With `enN` low, a rising or falling edge sampled on `dataIn` at a clock edge appears on `dataOut` exactly BASE + code×STEP clock edges later. Code 0 gives BASE edges, and pulse widths are kept.
- R2: The largest code, 2^CODE_W−1 (127 by default), gives a delay of BASE + 127×STEP edges.
- R3: While `enN` is low, `dataOutN` is always the logical inverse of `dataOut`.
- R4: While `enN` is high, `dataOut` is 0 and `dataOutN` is 1 in the same cycle, without waiting for a clock edge, whatever `dataIn` does.
- R5: The code is not latched. A change of `codeIn` moves the tap at once, so `dataOut` shows the stored sample at the new tap before the next clock edge.
- R6: When a clock edge samples a code b above the code a of the previous edge, `settleBusy` is 1 for exactly (b−a)×STEP cycles after that edge and then drops.
- R7: A decrease of the code starts no guard window, so an idle `settleBusy` stays 0.
- R8: A clock edge that sees `enN` go from low to high loads a clear window of code×STEP cycles. Every edge that samples `enN` high with `dataIn` high reloads that window.
- R9: Synchronous active-high `rst` clears all stored samples and stops any window. After reset `dataOut` is 0, `dataOutN` is 1 and `settleBusy` is 0, and the code present during reset does not start a guard window.
- R10: When a new window is loaded while another is running, the counter keeps whichever remaining count is longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| codeIn | input | CODE_W | Delay code, used unlatched |
| enN | input | 1 | Active-low output enable |
| dataIn | input | 1 | Signal to be delayed |
| dataOut | output | 1 | Delayed true output |
| dataOutN | output | 1 | Delayed complementary output |
| settleBusy | output | 1 | Guard or clear window still running |

## Verification
The delay is measured with isolated pulses at code 0, a small code, a middle code and the largest code. The rise time separates errors in the base term from errors in the step term, and the fall time shows whether the pulse width is kept. A line filled with a long run of ones followed by a short run of zeros is read at two codes with no clock edge in between. This shows that the tap follows the live code. Settle windows are counted cycle by cycle for a code increase, a code decrease, a plain disable, and a disable with an input pulse. Two overlapping cases, one where the new window is longer and one where it is shorter, show whether a load replaces the counter or keeps the larger value.

// File: rtl/tap_delay_pkg.sv
package tap_delay_pkg;

  // Strobes handed from control to the datapath.
  typedef struct packed {
    logic forceOff;   // hold outputs at disabled levels
    logic clearLine;  // wipe the stored samples
  } lineCtl_t;

endpackage

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl
  import tap_delay_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int STEP   = 1,
  parameter int BASE   = 1,
  parameter int TAP_W  = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              enN,
  input  logic              dataIn,
  output logic [TAP_W-1:0]  tapIdx,
  output lineCtl_t          ctl,
  output logic              settleBusy
);

  logic [CODE_W-1:0] prevCode;
  logic              enPrev;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  guardLoad;
  logic [CNT_W-1:0]  clearLoad;
  logic [CNT_W-1:0]  bigLoad;
  logic [CNT_W-1:0]  cntDec;
  logic [CNT_W-1:0]  cntNext;

  // Tap position follows the live code: no register on the way.
  assign tapIdx = TAP_W'(BASE - 1) + TAP_W'(codeIn) * TAP_W'(STEP);

  assign ctl.forceOff  = enN;
  assign ctl.clearLine = rst;

  always_comb begin
    guardLoad = '0;
    if (codeIn > prevCode)
      guardLoad = CNT_W'(codeIn - prevCode) * CNT_W'(STEP);
    clearLoad = '0;
    if (enN && (!enPrev || dataIn))
      clearLoad = CNT_W'(codeIn) * CNT_W'(STEP);
    bigLoad = (guardLoad > clearLoad) ? guardLoad : clearLoad;
    cntDec  = (cnt != '0) ? cnt - 1'b1 : '0;
    cntNext = (bigLoad > cntDec) ? bigLoad : cntDec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevCode <= codeIn;
      enPrev   <= enN;
      cnt      <= '0;
    end else begin
      prevCode <= codeIn;
      enPrev   <= enN;
      cnt      <= cntNext;
    end
  end

  assign settleBusy = (cnt != '0);

  // R6: a raised code always opens a guard window
  assert_guard_on_raise_R6: assert property (@(posedge clk) disable iff (rst)
    (codeIn > prevCode) |=> settleBusy);

  // R7: with no trigger, an idle flag stays idle
  assert_no_guard_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (!settleBusy && codeIn <= prevCode && !enN) |=> !settleBusy);

  // R8: a disable with a nonzero code opens a clear window
  assert_clear_window_R8: assert property (@(posedge clk) disable iff (rst)
    (enN && !enPrev && codeIn != '0) |=> settleBusy);

endmodule

// File: rtl/tap_delay_path.sv
module tap_delay_path
  import tap_delay_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int TAP_W = 7
) (
  input  logic             clk,
  input  logic             dataIn,
  input  logic [TAP_W-1:0] tapIdx,
  input  lineCtl_t         ctl,
  output logic             dataOut,
  output logic             dataOutN
);

  logic [DEPTH-1:0] sr;
  logic             tapBit;

  always_ff @(posedge clk) begin
    if (ctl.clearLine) sr <= '0;
    else               sr <= {sr[DEPTH-2:0], dataIn};
  end

  assign tapBit   = sr[tapIdx];
  assign dataOut  = ctl.forceOff ? 1'b0 : tapBit;
  assign dataOutN = ctl.forceOff ? 1'b1 : ~tapBit;

  // R3: enabled outputs never agree
  assert_complement_R3: assert property (@(posedge clk) disable iff (ctl.clearLine)
    !ctl.forceOff |-> (dataOutN != dataOut));

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line
  import tap_delay_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int STEP   = 1,
  parameter int BASE   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              enN,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOutN,
  output logic              settleBusy
);

  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam int DEPTH    = MAX_CODE * STEP + BASE;
  localparam int TAP_W    = $clog2(DEPTH);
  localparam int CNT_W    = $clog2(MAX_CODE * STEP + 1);

  lineCtl_t         ctl;
  logic [TAP_W-1:0] tapIdx;

  tap_delay_ctrl #(
    .CODE_W(CODE_W), .STEP(STEP), .BASE(BASE), .TAP_W(TAP_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .codeIn(codeIn), .enN(enN), .dataIn(dataIn),
    .tapIdx(tapIdx), .ctl(ctl), .settleBusy(settleBusy)
  );

  tap_delay_path #(.DEPTH(DEPTH), .TAP_W(TAP_W)) u_path (
    .clk(clk), .dataIn(dataIn), .tapIdx(tapIdx), .ctl(ctl),
    .dataOut(dataOut), .dataOutN(dataOutN)
  );

  // R4: disabled outputs sit at fixed levels
  assert_forced_levels_R4: assert property (@(posedge clk) disable iff (rst)
    enN |-> (!dataOut && dataOutN));

endmodule

// File: tb/tap_delay_line_bench.sv
module tap_delay_line_bench;

  localparam int CODE_W = 7;
  localparam int STEP   = 2;
  localparam int BASE   = 3;
  localparam int DEPTH  = 127 * STEP + BASE;

  logic clk = 0;
  logic rst, enN, dataIn;
  logic [CODE_W-1:0] codeIn;
  logic dataOut, dataOutN, settleBusy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  tap_delay_line #(.CODE_W(CODE_W), .STEP(STEP), .BASE(BASE)) u_tap_delay_line (
    .clk(clk), .rst(rst), .codeIn(codeIn), .enN(enN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutN(dataOutN), .settleBusy(settleBusy)
  );

  always #10 clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // Counts busy samples over n cycles after the current negedge.
  task automatic countBusy(int n, output int cnt);
    cnt = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (settleBusy) cnt++;
    end
  endtask

  task automatic testReset();
    rst = 1; codeIn = 7'd100; dataIn = 0; enN = 0;
    idle(3);
    rst = 0;
    @(negedge clk);
    check(dataOut == 0 && dataOutN == 1, "R9", "outputs after reset",
          {dataOut, dataOutN}, 1);
    check(settleBusy == 0, "R9", "busy after reset", settleBusy, 0);
    idle(2);
    check(settleBusy == 0, "R9", "no guard from reset code", settleBusy, 0);
    dataIn = 1;
    idle(300);
    dataIn = 0;
    @(negedge clk);
    check(dataOut == 1, "R9", "filled line reads one", dataOut, 1);
    rst = 1;
    idle(2);
    rst = 0;
    @(negedge clk);
    check(dataOut == 0, "R9", "line cleared by reset", dataOut, 0);
  endtask

  task automatic measureDelay(int code, int width, string req);
    int rise = -1, fall = -1, compErr = 0;
    int d = BASE + code * STEP;
    codeIn = CODE_W'(code); enN = 0; dataIn = 0;
    idle(DEPTH + 5);
    dataIn = 1;
    for (int n = 1; n <= d + width + 5; n++) begin
      @(negedge clk);
      if (rise < 0 && dataOut) rise = n;
      if (rise >= 0 && fall < 0 && !dataOut) fall = n;
      if (dataOutN == dataOut) compErr++;
      if (n == width) dataIn = 0;
    end
    check(rise == d, req, $sformatf("rise at code %0d", code), rise, d);
    check(fall == d + width, req, $sformatf("fall at code %0d", code), fall, d + width);
    check(compErr == 0, "R3", "complement mismatches", compErr, 0);
  endtask

  task automatic testUnlatched();
    enN = 0; codeIn = 0; dataIn = 1;
    idle(300);
    dataIn = 0;
    idle(20);
    codeIn = 7'd0;
    #1;
    check(dataOut == 0, "R5", "tap at code 0", dataOut, 0);
    codeIn = 7'd50;
    #1;
    check(dataOut == 1, "R5", "tap follows new code", dataOut, 1);
    codeIn = 7'd2;
    #1;
    check(dataOut == 0, "R5", "tap follows code back", dataOut, 0);
  endtask

  task automatic testRaise();
    int c;
    codeIn = 7'd5; enN = 0; dataIn = 0;
    idle(260);
    codeIn = 7'd12;
    @(negedge clk);
    check(settleBusy == 1, "R6", "busy right after raise", settleBusy, 1);
    countBusy(40, c);
    check(c + 1 == 14, "R6", "guard length 5->12", c + 1, 14);
  endtask

  task automatic testFall();
    int c;
    codeIn = 7'd20; enN = 0; dataIn = 0;
    idle(260);
    codeIn = 7'd5;
    countBusy(20, c);
    check(c == 0, "R7", "no guard on decrease", c, 0);
  endtask

  task automatic testDisable();
    int c = 0, forcedErr = 0;
    codeIn = 7'd10; enN = 0; dataIn = 0;
    idle(260);
    enN = 1;
    #1;
    check(dataOut == 0 && dataOutN == 1, "R4", "forced levels same cycle",
          {dataOut, dataOutN}, 1);
    countBusy(40, c);
    check(c == 20, "R8", "clear window length", c, 20);
    enN = 0;
    idle(30);
    enN = 1;
    c = 0;
    for (int n = 1; n <= 60; n++) begin
      @(negedge clk);
      if (settleBusy) c++;
      if (dataOut != 0 || dataOutN != 1) forcedErr++;
      if (n == 5) dataIn = 1;
      if (n == 6) dataIn = 0;
    end
    check(c == 25, "R8", "window restarted by input", c, 25);
    check(forcedErr == 0, "R4", "outputs forced despite input", forcedErr, 0);
    enN = 0;
    idle(30);
  endtask

  task automatic testOverlap();
    int c = 0;
    codeIn = 7'd0; enN = 0; dataIn = 0;
    idle(260);
    codeIn = 7'd10;
    for (int n = 1; n <= 50; n++) begin
      @(negedge clk);
      if (settleBusy) c++;
      if (n == 5) enN = 1;
    end
    check(c == 25, "R10", "longer clear window wins", c, 25);
    enN = 0; codeIn = 7'd0;
    idle(260);
    codeIn = 7'd20;
    c = 0;
    for (int n = 1; n <= 60; n++) begin
      @(negedge clk);
      if (settleBusy) c++;
      if (n == 3) codeIn = 7'd22;
    end
    check(c == 40, "R10", "shorter guard does not cut window", c, 40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    testReset();
    measureDelay(0, 20, "R1");
    measureDelay(1, 20, "R1");
    measureDelay(37, 24, "R1");
    measureDelay(127, 30, "R2");
    testUnlatched();
    testRaise();
    testFall();
    testDisable();
    testOverlap();
    done = 1;
    summary();
    $finish;
  end

endmodule